// File: doc/BRIEF.md
# Command-Preamble Write Protection Sequencer

This block watches the captured write transactions of a parallel nonvolatile byte memory: a one-cycle strobe with a 15-bit address and an 8-bit data byte. It recognises two keyed command sequences built from fixed address/data pairs. A three-write preamble turns protection on and opens the next page load. A six-write sequence clears protection. For every strobed write it returns a combinational permit, which the page-load controller uses to decide whether that byte may enter the page buffer.

While protection is off, ordinary writes pass straight through. While it is on, a write is permitted only inside an unlock window opened by the preamble. That window closes when the page-load controller signals a commit, or when no write arrives within the byte-load interval. Steps of a sequence must also arrive within that interval of each other. The protection flag stands in for a nonvolatile cell. Reset loads it from a parameter; only the two sequences change it.

The sequencer has these states:
- `ST_IDLE`: waiting for a first step.
- `ST_K1`: after AA@5555.
- `ST_K2`: after 55@2AAA.
- `ST_OPEN`: unlock window.
- `ST_OFF3`: after 80@5555.
- `ST_OFF4`: after AA@5555.
- `ST_OFF5`: after 55@2AAA.

The sequencer moves between these states as follows:
- K2 goes to OPEN on A0@5555 and sets the flag.
- K2 goes to OFF3 on 80@5555.
- OFF5 goes to IDLE on 20@5555 and clears the flag.
- Any other write in a step state restarts the sequence. It goes to K1 if the write is AA@5555, and to IDLE otherwise.
- A gap timeout returns any non-idle state to IDLE.
- A commit returns OPEN to IDLE.

Top module: `cmd_lock_guard`

## Requirements
- R1: After reset `prot_on` equals parameter `PROT_INIT` (default 0), the sequencer is idle, and `wr_permit` is 0 whenever `wr_stb` is 0.
- R2: With protection off, every strobed write is permitted, except the write that completes a sequence. Those are A0@5555 after AA@5555 and 55@2AAA, and 20@5555 as the sixth disable step. Both completing writes are refused.
- R3: The enable sequence is AA@5555, then 55@2AAA, then A0@5555 (hex). `prot_on` is 1 from the clock edge that accepts the third write, even if no data write follows.
- R4: With protection on and no open unlock window, every write is refused, including each step of a command sequence.
- R5: After the enable sequence, writes are permitted until `page_commit` is seen. Once committed, the window is closed and the next write is refused while protection is on.
- R6: A step or data write separated from the previous accepted write by at most `WINDOW` clock edges continues the sequence or window. With a gap of `WINDOW+1` edges the sequencer has already returned to idle, and `prot_on` is unchanged.
- R7: A write that does not match the expected next step returns the sequencer to idle without changing `prot_on`. If that write is AA@5555 it is taken as a fresh first step.
- R8: The disable sequence is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. `prot_on` is 0 from the edge that accepts the sixth write, and later ordinary writes are permitted.
- R9: A write in the same cycle as `page_commit` while the window is open is judged as if the sequencer were idle. It is refused when protection is on, and it may start a new sequence.
- R10: `prot_on` changes only at the edge of a strobed write that completes the enable sequence or the disable sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the flag from PROT_INIT |
| wr_stb | input | 1 | One-cycle strobe of a captured write |
| wr_addr | input | 15 | Captured write address |
| wr_data | input | 8 | Captured write data |
| page_commit | input | 1 | Pulse from page-load controller: buffered page committed |
| wr_permit | output | 1 | Current strobed write may enter the page buffer |
| prot_on | output | 1 | Protection flag |

## Verification
Two events can fall in the same cycle. The first is a commit and a write arriving while the window is open. The second is a timeout and a write on the last legal edge of the window. The bench provokes the commit collision directly: it sends AA@5555 together with `page_commit`, expects that write to be refused, and expects it to count as step one of a new preamble. It provokes the timeout edge by spacing steps exactly `WINDOW` and `WINDOW+1` edges apart. A reference model, written as bench tasks, checks both cases. The same model checks a long stream of random strobes, keyed addresses, keyed data bytes and commits.

// File: rtl/cmd_lock_pkg.sv
`timescale 1ns/1ps
package cmd_lock_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_AA      = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_55      = 8'h55;
    localparam logic [DATA_W-1:0] KEY_ON      = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_OFF_PRE = 8'h80;
    localparam logic [DATA_W-1:0] KEY_OFF     = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_OFF3,
        ST_OFF4,
        ST_OFF5,
        ST_OPEN
    } lock_state_e;

    typedef struct packed {
        logic aa_hi;
        logic k55_lo;
        logic on_hi;
        logic offpre_hi;
        logic off_hi;
    } step_hits_t;
endpackage

// File: rtl/cmd_step_match.sv
`timescale 1ns/1ps
module cmd_step_match
    import cmd_lock_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output step_hits_t        hits
);
    logic at_hi;
    logic at_lo;

    always_comb begin
        at_hi          = (addr == KEY_ADDR_HI);
        at_lo          = (addr == KEY_ADDR_LO);
        hits.aa_hi     = at_hi && (data == KEY_AA);
        hits.k55_lo    = at_lo && (data == KEY_55);
        hits.on_hi     = at_hi && (data == KEY_ON);
        hits.offpre_hi = at_hi && (data == KEY_OFF_PRE);
        hits.off_hi    = at_hi && (data == KEY_OFF);
    end
endmodule

// File: rtl/cmd_gap_timer.sv
`timescale 1ns/1ps
module cmd_gap_timer #(
    parameter int WINDOW = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expire
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the gap counter saturates at the last legal edge
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R6: a clear always restarts the count from zero
    p_clear_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/prot_flag_reg.sv
`timescale 1ns/1ps
module prot_flag_reg #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

    // R10: the flag moves only on a set or clear request
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/cmd_lock_guard.sv
`timescale 1ns/1ps
module cmd_lock_guard
    import cmd_lock_pkg::*;
#(
    parameter int WINDOW    = 20000,
    parameter bit PROT_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              page_commit,
    output logic              wr_permit,
    output logic              prot_on
);
    lock_state_e state_q;
    lock_state_e eff_state;
    lock_state_e nxt_state;
    lock_state_e restart_state;
    step_hits_t  hits;
    logic        expire;
    logic        set_req;
    logic        clr_req;
    logic        completes;
    logic        timer_clear;

    cmd_step_match u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hits (hits)
    );

    assign timer_clear = wr_stb || (state_q == ST_IDLE);

    cmd_gap_timer #(.WINDOW(WINDOW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .expire (expire)
    );

    prot_flag_reg #(.INIT(PROT_INIT)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_req),
        .clr   (clr_req),
        .q     (prot_on)
    );

    // A commit closes the window before a same-cycle write is judged
    always_comb begin
        eff_state     = (state_q == ST_OPEN && page_commit) ? ST_IDLE : state_q;
        restart_state = hits.aa_hi ? ST_K1 : ST_IDLE;
    end

    // Next-state and sequence decode
    always_comb begin
        nxt_state = eff_state;
        set_req   = 1'b0;
        clr_req   = 1'b0;
        completes = 1'b0;
        if (wr_stb) begin
            unique case (eff_state)
                ST_IDLE: nxt_state = restart_state;
                ST_K1:   nxt_state = hits.k55_lo ? ST_K2 : restart_state;
                ST_K2: begin
                    if (hits.on_hi) begin
                        nxt_state = ST_OPEN;
                        set_req   = 1'b1;
                        completes = 1'b1;
                    end else if (hits.offpre_hi) begin
                        nxt_state = ST_OFF3;
                    end else begin
                        nxt_state = restart_state;
                    end
                end
                ST_OFF3: nxt_state = hits.aa_hi ? ST_OFF4 : ST_IDLE;
                ST_OFF4: nxt_state = hits.k55_lo ? ST_OFF5 : restart_state;
                ST_OFF5: begin
                    if (hits.off_hi) begin
                        nxt_state = ST_IDLE;
                        clr_req   = 1'b1;
                        completes = 1'b1;
                    end else begin
                        nxt_state = restart_state;
                    end
                end
                ST_OPEN: nxt_state = ST_OPEN;
                default: nxt_state = ST_IDLE;
            endcase
        end else if (eff_state != ST_IDLE && expire) begin
            nxt_state = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt_state;
        end
    end

    // Outputs
    always_comb begin
        wr_permit = wr_stb &&
                    ((eff_state == ST_OPEN) || (!prot_on && !completes));
    end

    // R1: no permit without a strobe
    p_permit_needs_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> wr_stb);
    // R4: while protected, only the open window lets a write through
    p_prot_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && wr_permit) |-> (state_q == ST_OPEN && !page_commit));
    // R3: the flag rises only after an A0@5555 write
    p_rise_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_stb && hits.on_hi));
    // R8: the flag falls only after a 20@5555 write
    p_fall_on_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_stb && hits.off_hi));
    // R5: a commit always closes the window
    p_commit_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && page_commit) |=> state_q != ST_OPEN);
    // R10: without a strobe the flag holds
    p_flag_needs_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(prot_on));
endmodule

// File: tb/tb_cmd_lock_guard.sv
`timescale 1ns/1ps
module tb_cmd_lock_guard;
    localparam int W = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_commit = 1'b0;
    logic        wr_permit;
    logic        prot_on;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state: 0 idle,1 k1,2 k2,3 off3,4 off4,5 off5,6 open
    int mstate = 0;
    bit mprot = 0;
    int mgap = 0;

    always #2.5 clk = ~clk;

    cmd_lock_guard #(.WINDOW(W), .PROT_INIT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .page_commit(page_commit),
        .wr_permit(wr_permit), .prot_on(prot_on)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic int restart_of(input logic [14:0] a, input logic [7:0] d);
        return (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
    endfunction

    // Expected behaviour from the requirements: returns permit, next state, next flag
    task automatic model_eval(input logic s, input logic [14:0] a, input logic [7:0] d,
                              input logic c, output logic perm, output int ns, output bit np);
        int eff;
        bit done_seq;
        eff = (mstate == 6 && c) ? 0 : mstate;   // R9
        ns = eff;
        np = mprot;
        done_seq = 0;
        if (s) begin
            case (eff)
                0: ns = restart_of(a, d);
                1: ns = (a == 15'h2AAA && d == 8'h55) ? 2 : restart_of(a, d);
                2: begin
                    if (a == 15'h5555 && d == 8'hA0) begin ns = 6; np = 1; done_seq = 1; end
                    else if (a == 15'h5555 && d == 8'h80) ns = 3;
                    else ns = restart_of(a, d);
                end
                3: ns = (a == 15'h5555 && d == 8'hAA) ? 4 : 0;
                4: ns = (a == 15'h2AAA && d == 8'h55) ? 5 : restart_of(a, d);
                5: begin
                    if (a == 15'h5555 && d == 8'h20) begin ns = 0; np = 0; done_seq = 1; end
                    else ns = restart_of(a, d);
                end
                default: ns = 6;
            endcase
        end else if (eff != 0 && mgap == W - 1) begin
            ns = 0;
        end
        perm = s && ((eff == 6) || (!mprot && !done_seq));
    endtask

    task automatic cyc(input logic s, input logic [14:0] a, input logic [7:0] d,
                       input logic c, input string tag);
        logic perm;
        int ns;
        bit np;
        @(negedge clk);
        wr_stb = s; wr_addr = a; wr_data = d; page_commit = c;
        #1;
        model_eval(s, a, d, c, perm, ns, np);
        check(wr_permit, perm, {tag, " permit"});
        check(prot_on, mprot, {tag, " prot_on"});
        @(posedge clk);
        if (s || ns == 0) mgap = 0;
        else if (mgap < W - 1) mgap++;
        mstate = ns;
        mprot = np;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 15'h0, 8'h0, 0, tag);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
        cyc(1, a, d, 0, tag);
    endtask

    task automatic preamble(input int gap, input string tag);
        wr(15'h5555, 8'hAA, tag); idle(gap, tag);
        wr(15'h2AAA, 8'h55, tag); idle(gap, tag);
        wr(15'h5555, 8'hA0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(prot_on, 1'b0, "R1 reset prot_on");
        check(wr_permit, 1'b0, "R1 reset permit");
        idle(2, "R1 idle");

        wr(15'h0100, 8'h12, "R2 plain write unprotected");
        // R3 enable; completing A0 write refused (R2)
        preamble(0, "R3 enable");
        @(negedge clk); #1;
        check(prot_on, 1'b1, "R3 prot after enable");
        wr(15'h0200, 8'h01, "R5 data in window");
        wr(15'h0201, 8'h02, "R5 data in window");
        cyc(0, 15'h0, 8'h0, 1, "R5 commit");
        wr(15'h0001, 8'h77, "R4 write after commit refused");
        idle(3, "R4 idle");

        // R6 steps exactly W edges apart stay valid
        preamble(W - 1, "R6 gap at limit");
        idle(W - 1, "R6 idle in window");
        wr(15'h0300, 8'h33, "R6 data at limit");
        cyc(0, 15'h0, 8'h0, 1, "R6 commit");
        // R6 gap of W+1 edges drops the sequence
        wr(15'h5555, 8'hAA, "R6 late seq");
        wr(15'h2AAA, 8'h55, "R6 late seq");
        idle(W, "R6 late gap");
        wr(15'h5555, 8'hA0, "R6 late third step refused");
        wr(15'h0301, 8'h44, "R6 data after late seq refused");
        @(negedge clk); #1;
        check(prot_on, 1'b1, "R6 prot unchanged");

        // R7 mismatch and restart
        wr(15'h5555, 8'hAA, "R7 step1");
        wr(15'h2AAA, 8'h56, "R7 wrong data");
        wr(15'h5555, 8'hA0, "R7 stray A0 refused");
        wr(15'h5555, 8'hAA, "R7 step1 again");
        wr(15'h5555, 8'hAA, "R7 restart on AA");
        wr(15'h2AAA, 8'h55, "R7 step2");
        wr(15'h5555, 8'hA0, "R7 step3");
        wr(15'h0400, 8'h55, "R7 data after restart");
        cyc(0, 15'h0, 8'h0, 1, "R7 commit");

        // R9 commit collides with a write that starts a new preamble
        preamble(0, "R9 open");
        wr(15'h0500, 8'h66, "R9 data");
        cyc(1, 15'h5555, 8'hAA, 1, "R9 write with commit refused");
        wr(15'h2AAA, 8'h55, "R9 step2");
        wr(15'h5555, 8'hA0, "R9 step3");
        wr(15'h0501, 8'h67, "R9 data in new window");
        cyc(0, 15'h0, 8'h0, 1, "R9 commit");

        // R6 window expires without commit
        preamble(0, "R6 window expiry");
        idle(W, "R6 expiry wait");
        wr(15'h0600, 8'h01, "R6 data after expiry refused");

        // R8 disable
        wr(15'h5555, 8'hAA, "R8 d1");
        wr(15'h2AAA, 8'h55, "R8 d2");
        wr(15'h5555, 8'h80, "R8 d3");
        wr(15'h5555, 8'hAA, "R8 d4");
        wr(15'h2AAA, 8'h55, "R8 d5");
        wr(15'h5555, 8'h20, "R8 d6");
        @(negedge clk); #1;
        check(prot_on, 1'b0, "R8 prot after disable");
        wr(15'h0700, 8'h99, "R8 write permitted");

        // R10 random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [14:0] a;
            logic [7:0] d;
            logic s;
            logic c;
            int pick;
            pick = $urandom_range(0, 3);
            a = (pick == 0) ? 15'($urandom) : (pick == 1 ? 15'h2AAA : 15'h5555);
            pick = $urandom_range(0, 6);
            case (pick)
                0: d = 8'hAA;
                1: d = 8'h55;
                2: d = 8'hA0;
                3: d = 8'h80;
                4: d = 8'h20;
                default: d = 8'($urandom);
            endcase
            s = ($urandom_range(0, 2) != 0);
            c = ($urandom_range(0, 9) == 0);
            cyc(s, a, d, c, "R10 random");
            if ($urandom_range(0, 40) == 0) idle($urandom_range(W - 2, W + 2), "R6 random gap");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule